// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the 8-bit status register of a serial memory with a supervisor. It also decides, one request at a time, whether a write may go ahead. A command decoder in front of it sends single-cycle strobes:

- set or clear the write-enable latch
- set or clear the user flag
- a status write, with its data
- an array write, with its byte address

The block answers each write request one cycle later with a grant pulse or a deny pulse. It returns the live status value for readback.

Four inputs decide a write request:

- **Write-enable latch.** It must be set before any write is granted.
- **Lock select field.** Two bits that fence off the top quarter, the top half or all of the array.
- **Protect-enable bit.** When it is set, the external active-low write-protect pin can freeze the status register. With the pin tied low, the array regions locked before protect-enable was set can no longer be opened, so they behave as in-circuit ROM.

A granted write stays pending until the write-cycle timer reports completion. At completion a status write's data is committed and the write-enable latch drops. The nonvolatile fields are ordinary flops that take a parameter value at power-on reset. The busy bit mirrors an input from the write-cycle timer.

Top module: `sreg_guard`

## Requirements
- R1: After power-on reset the status reads the boot value of the nonvolatile fields, with the flag and write-enable latch at 0, and neither grant nor deny is asserted.
- R2: The status readback has this layout: bit 7 protect-enable, bit 6 flag, bits 5:4 watchdog select, bits 3:2 lock select, bit 1 write-enable latch, bit 0 busy. Bit 0 follows `busy_in` in the same cycle.
- R3: `wen_set` sets the write-enable latch and `wen_clr` clears it. When both arrive together, clear wins.
- R4: `flag_set` sets the flag and `flag_clr` clears it. When both arrive together, clear wins.
- R5: While the write-enable latch is 0, every status or array write request is denied.
- R6: The lock select field fences off a range of the array, with the array size set by a parameter:
  - 00: no address is locked.
  - 01: the top quarter is locked (0x1800-0x1FFF for 8K).
  - 10: the top half is locked (0x1000-0x1FFF for 8K).
  - 11: every address is locked.
  - An array write to a locked address is always denied.
- R7: With the latch set, protect-enable 1 and `wp_n` low, status writes are denied. Array writes to unlocked addresses are still granted.
- R8: With the latch set and either protect-enable 0 or `wp_n` high, status writes are granted.
- R9: Each request gets exactly one of `wr_grant` or `wr_deny`, pulsed in the cycle after the request. The two are never high together.
- R10: A granted write stays pending until `wr_done`.
  - Every write request made while a write is pending is denied.
  - Completion clears the write-enable latch.
  - A granted status write commits data bits 7:2 at completion, even if `wp_n` falls in the meantime.
- R11: `wr_done` with no write pending changes nothing.
- R12: Latch and flag commands in the same cycle as a completion apply after it. A `wen_set` arriving with `wr_done` leaves the latch set.
- R13: When `sr_wr` and `arr_wr` arrive together, only the status request is judged and answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wen_set | input | 1 | Set write-enable latch strobe |
| wen_clr | input | 1 | Clear write-enable latch strobe |
| flag_set | input | 1 | Set user flag strobe |
| flag_clr | input | 1 | Clear user flag strobe |
| sr_wr | input | 1 | Status write request strobe |
| sr_wdata | input | 6 | Status write data for bits 7:2 |
| arr_wr | input | 1 | Array write request strobe |
| arr_addr | input | ADDR_W | Array byte address of the write request |
| wp_n | input | 1 | Write-protect pin, low protects |
| wr_done | input | 1 | Write-cycle completion strobe from the timer |
| busy_in | input | 1 | Busy indication from the write-cycle timer |
| wr_grant | output | 1 | Request granted, one-cycle pulse |
| wr_deny | output | 1 | Request denied, one-cycle pulse |
| sr_rd | output | 8 | Status readback |

## Verification
Two events can fall in the same cycle:

- A write-cycle completion, which clears the latch and commits pending status data.
- A command strobe or a new write request.

The bench provokes this in directed steps: `wen_set` together with `wr_done`, and a request together with `wr_done`. A random phase then asserts `wr_done` and the strobes independently, so the overlap recurs many times. Each cycle's grant or deny result and the status readback are judged against a bench model. In that model completion is applied first and the commands after it, and a request made in the completion cycle still counts as made during the pending write.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

  localparam int unsigned SR_W     = 8;
  localparam int unsigned POS_PEN  = 7;
  localparam int unsigned POS_FLAG = 6;
  localparam int unsigned POS_WEL  = 1;
  localparam int unsigned POS_BUSY = 0;

  typedef enum logic [1:0] {
    LOCK_NONE     = 2'b00,
    LOCK_TOP_QTR  = 2'b01,
    LOCK_TOP_HALF = 2'b10,
    LOCK_ALL      = 2'b11
  } lock_e;

  typedef struct packed {
    logic       prot_en;
    logic [1:0] wdog_sel;
    logic [1:0] lock_sel;
  } nvcfg_t;

  localparam int unsigned NV_W = $bits(nvcfg_t);

endpackage

// File: rtl/sreg_lock_decode.sv
module sreg_lock_decode
  import sreg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [1:0]        lock_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);

  generate
    if (ADDR_W >= 2) begin : g_frac
      logic [1:0] top2;
      assign top2 = addr[ADDR_W-1 -: 2];
      always_comb begin
        unique case (lock_e'(lock_sel))
          LOCK_NONE:     locked = 1'b0;
          LOCK_TOP_QTR:  locked = (top2 == 2'b11);
          LOCK_TOP_HALF: locked = top2[1];
          default:       locked = 1'b1;
        endcase
      end
    end else begin : g_tiny
      logic unused_addr;
      assign unused_addr = ^addr;
      assign locked = (lock_sel != 2'b00);
    end
  endgenerate

endmodule

// File: rtl/sreg_grant_logic.sv
module sreg_grant_logic (
  input  logic sr_req,
  input  logic arr_req,
  input  logic wel,
  input  logic pending,
  input  logic prot_en,
  input  logic wp_n,
  input  logic locked,
  output logic sr_take,
  output logic arr_take,
  output logic deny
);

  logic arr_only;
  logic base_ok;
  logic sr_ok;
  logic arr_ok;

  always_comb begin
    arr_only = arr_req & ~sr_req;
    base_ok  = wel & ~pending;
    sr_ok    = base_ok & ~(prot_en & ~wp_n);
    arr_ok   = base_ok & ~locked;
    sr_take  = sr_req & sr_ok;
    arr_take = arr_only & arr_ok;
    deny     = (sr_req & ~sr_ok) | (arr_only & ~arr_ok);
  end

endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 8192,
  parameter int unsigned ADDR_W      = $clog2(ARRAY_BYTES),
  parameter logic [4:0]  NV_BOOT     = 5'b0_00_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_set,
  input  logic              wen_clr,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic              sr_wr,
  input  logic [7:2]        sr_wdata,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_n,
  input  logic              wr_done,
  input  logic              busy_in,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic [SR_W-1:0]   sr_rd
);

  localparam nvcfg_t NV_RST = nvcfg_t'(NV_BOOT);
  localparam int unsigned PD_W = NV_W + 1;

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_q_n <= rs_meta;
    end
  end

  nvcfg_t          nv_q, nv_d;
  logic            flag_q, flag_d;
  logic            wel_q, wel_d;
  logic            pend_q, pend_d;
  logic            pend_sr_q, pend_sr_d;
  logic [PD_W-1:0] pend_data_q;
  logic            grant_q, deny_q;
  logic            locked;
  logic            sr_take, arr_take, deny_nxt;
  logic            take, commit, commit_sr;

  sreg_lock_decode #(.ADDR_W(ADDR_W)) u_lock (
    .lock_sel (nv_q.lock_sel),
    .addr     (arr_addr),
    .locked   (locked)
  );

  sreg_grant_logic u_grant (
    .sr_req   (sr_wr),
    .arr_req  (arr_wr),
    .wel      (wel_q),
    .pending  (pend_q),
    .prot_en  (nv_q.prot_en),
    .wp_n     (wp_n),
    .locked   (locked),
    .sr_take  (sr_take),
    .arr_take (arr_take),
    .deny     (deny_nxt)
  );

  // next state
  always_comb begin
    take      = sr_take | arr_take;
    commit    = wr_done & pend_q;
    commit_sr = commit & pend_sr_q;

    nv_d   = nv_q;
    flag_d = flag_q;
    if (commit_sr) begin
      nv_d.prot_en  = pend_data_q[5];
      flag_d        = pend_data_q[4];
      nv_d.wdog_sel = pend_data_q[3:2];
      nv_d.lock_sel = pend_data_q[1:0];
    end
    if (flag_clr)      flag_d = 1'b0;
    else if (flag_set) flag_d = 1'b1;

    if (wen_set && !wen_clr)   wel_d = 1'b1;
    else if (wen_clr || commit) wel_d = 1'b0;
    else                        wel_d = wel_q;

    if (take)        pend_d = 1'b1;
    else if (commit) pend_d = 1'b0;
    else             pend_d = pend_q;

    pend_sr_d = take ? sr_take : pend_sr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      nv_q      <= NV_RST;
      flag_q    <= 1'b0;
      wel_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_sr_q <= 1'b0;
      grant_q   <= 1'b0;
      deny_q    <= 1'b0;
    end else begin
      nv_q      <= nv_d;
      flag_q    <= flag_d;
      wel_q     <= wel_d;
      pend_q    <= pend_d;
      pend_sr_q <= pend_sr_d;
      grant_q   <= take;
      deny_q    <= deny_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_data_q <= '0;
    end else if (sr_take) begin
      pend_data_q <= sr_wdata;
    end
  end

  assign wr_grant = grant_q;
  assign wr_deny  = deny_q;

  always_comb begin
    sr_rd           = '0;
    sr_rd[POS_PEN]  = nv_q.prot_en;
    sr_rd[POS_FLAG] = flag_q;
    sr_rd[5:4]      = nv_q.wdog_sel;
    sr_rd[3:2]      = nv_q.lock_sel;
    sr_rd[POS_WEL]  = wel_q;
    sr_rd[POS_BUSY] = busy_in;
  end

endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wen_set,
  input logic       wen_clr,
  input logic       flag_set,
  input logic       flag_clr,
  input logic       sr_wr,
  input logic       arr_wr,
  input logic       wp_n,
  input logic       wr_done,
  input logic       wr_grant,
  input logic       wr_deny,
  input logic [7:0] sr_rd,
  input logic       pend_q
);

  assert_one_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_deny));

  assert_no_latch_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr || arr_wr) && !sr_rd[1] |=> wr_deny);

  assert_pin_blocks_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr && sr_rd[7] && !wp_n |=> wr_deny);

  assert_all_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr && !sr_wr && (sr_rd[3:2] == 2'b11) |=> wr_deny);

  assert_pending_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && (sr_wr || arr_wr) |=> wr_deny);

  assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done && !pend_q && !wen_set && !wen_clr && !flag_set && !flag_clr
    |=> $stable(sr_rd[7:1]));

  assert_latch_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wen_set && !wen_clr |=> sr_rd[1]);

endmodule

bind sreg_guard sreg_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .wen_set  (wen_set),
  .wen_clr  (wen_clr),
  .flag_set (flag_set),
  .flag_clr (flag_clr),
  .sr_wr    (sr_wr),
  .arr_wr   (arr_wr),
  .wp_n     (wp_n),
  .wr_done  (wr_done),
  .wr_grant (wr_grant),
  .wr_deny  (wr_deny),
  .sr_rd    (sr_rd),
  .pend_q   (pend_q)
);

// File: tb/test_sreg_guard.sv
module test_sreg_guard;

  localparam int unsigned AW = 13;
  localparam logic [4:0]  BOOT = 5'b1_10_01;

  logic clk = 1'b0;
  logic rst_n;
  logic wen_set, wen_clr, flag_set, flag_clr, sr_wr, arr_wr, wp_n, wr_done, busy_in;
  logic [7:2] sr_wdata;
  logic [AW-1:0] arr_addr;
  logic wr_grant, wr_deny;
  logic [7:0] sr_rd;

  always #2.5 clk = ~clk;

  sreg_guard #(.ARRAY_BYTES(8192), .NV_BOOT(BOOT)) i_sreg_guard (
    .clk(clk), .rst_n(rst_n), .wen_set(wen_set), .wen_clr(wen_clr),
    .flag_set(flag_set), .flag_clr(flag_clr), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .wp_n(wp_n), .wr_done(wr_done),
    .busy_in(busy_in), .wr_grant(wr_grant), .wr_deny(wr_deny), .sr_rd(sr_rd)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic m_pen, m_flag, m_wel, m_pend, m_pend_sr;
  logic [1:0] m_wd, m_bl;
  logic [5:0] m_pdata;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic locked_f(input logic [1:0] bl, input logic [AW-1:0] a);
    case (bl)
      2'b00:   return 1'b0;
      2'b01:   return a >= 13'h1800;
      2'b10:   return a >= 13'h1000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic idle();
    wen_set = 0; wen_clr = 0; flag_set = 0; flag_clr = 0;
    sr_wr = 0; arr_wr = 0; wr_done = 0;
  endtask

  // one clock step: model update, edge, compare answer and status
  task automatic cyc(input string tg, input string ts);
    logic sreq, areq, sok, aok, eg, ed, commit;
    logic [7:0] esr;
    sreq = sr_wr;
    areq = arr_wr & ~sr_wr;
    sok = m_wel & ~m_pend & ~(m_pen & ~wp_n);
    aok = m_wel & ~m_pend & ~locked_f(m_bl, arr_addr);
    eg = (sreq & sok) | (areq & aok);
    ed = (sreq | areq) & ~eg;
    commit = wr_done & m_pend;
    if (commit && m_pend_sr) {m_pen, m_flag, m_wd, m_bl} = m_pdata;
    if (flag_clr) m_flag = 0; else if (flag_set) m_flag = 1;
    if (wen_set && !wen_clr) m_wel = 1; else if (wen_clr || commit) m_wel = 0;
    if (eg) begin m_pend = 1; m_pend_sr = sreq; m_pdata = sr_wdata; end
    else if (commit) m_pend = 0;
    esr = {m_pen, m_flag, m_wd, m_bl, m_wel, busy_in};
    @(negedge clk);
    check({6'd0, wr_grant, wr_deny}, {6'd0, eg, ed}, tg);
    check(sr_rd, esr, ts);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; idle(); wp_n = 1; busy_in = 0; sr_wdata = '0; arr_addr = '0;
    {m_pen, m_wd, m_bl} = BOOT; m_flag = 0; m_wel = 0; m_pend = 0; m_pend_sr = 0; m_pdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(sr_rd, 8'b1010_0100, "R1");
    check({6'd0, wr_grant, wr_deny}, 8'd0, "R1");
    busy_in = 1; #1 check({7'd0, sr_rd[0]}, 8'd1, "R2"); busy_in = 0;

    arr_wr = 1; arr_addr = 13'h0010; cyc("R5", "R5");
    sr_wr = 1; sr_wdata = 6'b0; cyc("R5", "R5");
    wen_set = 1; cyc("R3", "R3");
    wen_set = 1; wen_clr = 1; cyc("R3", "R3");
    wen_set = 1; cyc("R3", "R3");
    flag_set = 1; cyc("R4", "R4");
    flag_set = 1; flag_clr = 1; cyc("R4", "R4");
    arr_wr = 1; arr_addr = 13'h17FF; cyc("R6", "R6");
    busy_in = 1; arr_wr = 1; arr_addr = 13'h0000; cyc("R10", "R2");
    wr_done = 1; cyc("R10", "R10");
    busy_in = 0; wen_set = 1; cyc("R3", "R3");
    arr_wr = 1; arr_addr = 13'h1800; cyc("R6", "R6");
    wp_n = 0; sr_wr = 1; sr_wdata = 6'b0; cyc("R7", "R7");
    arr_wr = 1; arr_addr = 13'h0010; cyc("R7", "R7");
    wr_done = 1; cyc("R10", "R10");
    wen_set = 1; cyc("R3", "R3");
    wp_n = 1; sr_wr = 1; sr_wdata = 6'b0_1_01_10; cyc("R8", "R8");
    wp_n = 0; cyc("R10", "R10");
    wr_done = 1; cyc("R10", "R10");
    wr_done = 1; cyc("R11", "R11");
    wen_set = 1; cyc("R3", "R3");
    arr_wr = 1; arr_addr = 13'h0FFF; cyc("R6", "R6");
    arr_wr = 1; arr_addr = 13'h1000; wr_done = 1; wen_set = 1; cyc("R10", "R12");
    sr_wr = 1; arr_wr = 1; arr_addr = 13'h0000; sr_wdata = 6'b0_0_11_11; cyc("R13", "R13");
    wr_done = 1; cyc("R10", "R10");
    wen_set = 1; cyc("R3", "R3");
    arr_wr = 1; arr_addr = 13'h0000; cyc("R6", "R6");

    for (int i = 0; i < 600; i++) begin
      wen_set  = ($urandom % 4) == 0;
      wen_clr  = ($urandom % 10) == 0;
      flag_set = ($urandom % 10) == 0;
      flag_clr = ($urandom % 10) == 0;
      sr_wr    = ($urandom % 7) == 0;
      arr_wr   = ($urandom % 3) == 0;
      wr_done  = ($urandom % 5) == 0;
      wp_n     = ($urandom % 10) < 7;
      busy_in  = $urandom % 2;
      sr_wdata = 6'($urandom);
      arr_addr = AW'($urandom);
      cyc("R9", "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule